// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O peripheral that sits behind a small synchronous register bus. The bus has a one-cycle write strobe, a one-cycle read strobe, a two-bit word offset, write data and registered read data. The pin count equals the register width, which can be 8, 16, 32 or 64 bits. The block does not drive pads directly. It presents an output-value vector and an output-enable vector for external tri-state buffers, and it takes an input vector that it synchronizes before any read.

Three choices are fixed at build time. The first is the output update style: one data register that replaces the latch, a set/clear register pair, or a set-only register that holds the full output value beside a read-only data register. The second is the direction control: none, a register in which 1 means output, or a register in which 1 means input. The third is an optional reversed numbering, in which logical pin n is tied to register bit WIDTH-1-n. Software reads the data offset to see each pin's level. A pin configured as output returns its latch value, and a pin configured as input returns its synchronized input level.

Top module: `gpio_mmio`

## Requirements
- R1: The pin vectors and the data registers are all WIDTH bits wide. WIDTH must be 8, 16, 32 or 64. A width outside that set, or a build that enables both direction options, is rejected at elaboration.
- R2: In single-register style (OUT_STYLE = OUT_SINGLE), a write to offset 0 replaces the whole output latch. Writes to offsets 1 and 2 leave the latch unchanged.
- R3: In set/clear style (OUT_STYLE = OUT_SETCLR), each 1 bit written to offset 1 sets the matching latch bit, and each 1 bit written to offset 2 clears it. Bits written 0 leave the latch unchanged, and writes to offset 0 are ignored.
- R4: In set-only style (OUT_STYLE = OUT_SETONLY), a write to offset 1 replaces the whole latch. Writes to offsets 0 and 2 leave the latch unchanged.
- R5: With DIR_OUT_EN = 1, offset 3 holds the direction register. Bit value 1 makes the pin an output (pin_oe high) and 0 makes it an input.
- R6: With DIR_IN_SEL = 1, offset 3 holds the direction register with inverted meaning. Bit value 1 makes the pin an input and 0 makes it an output.
- R7: With neither direction option enabled, pin_oe is all ones at all times. Writes to offset 3 have no effect, and reads of offset 3 return zero.
- R8: With REVERSE = 1, register bit b drives pin_out[WIDTH-1-b] and pin_oe[WIDTH-1-b], and it reads back from pin_in[WIDTH-1-b]. With REVERSE = 0, register bit b maps to pin b.
- R9: A read of offset 0 returns the latch bit for each output pin and the input level for each input pin. The input level passes through a two-flop synchronizer, so a pin_in value held for two rising edges is the value a read returns.
- R10: A read of offset 1 returns the latch in set/clear and set-only styles, and returns zero in single style. A read of offset 2 always returns zero.
- R11: Synchronous active-high reset clears the output latch and makes every pin an input. In input-select mode this means the direction register reads all ones. With no direction option, pin_oe stays all ones.
- R12: rdata is loaded on the rising edge that samples rd_en high. On every cycle without a read strobe, rdata keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 2 | Word offset: 0 data, 1 set, 2 clear, 3 direction |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Pin input levels, asynchronous to clk |
| pin_out | output | WIDTH | Output value per pin |
| pin_oe | output | WIDTH | Output enable per pin, 1 = drive |

## Verification
A write changes pin_out and pin_oe on the rising edge that samples the strobe, so the bench checks both vectors at the next falling edge. A read loads rdata on the edge that samples rd_en, and the bench compares rdata at the following falling edge. It then waits one idle cycle and compares rdata again to confirm the value was held. A pin_in change needs two rising edges to pass the synchronizer, so the bench holds each new input pattern for two full cycles before the read strobe is driven. As a result, every data read sees the settled input value.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

  typedef enum logic [1:0] {
    OUT_SINGLE  = 2'd0,
    OUT_SETCLR  = 2'd1,
    OUT_SETONLY = 2'd2
  } out_style_e;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_SET   = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_CLEAR = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 2'd3;

  function automatic bit width_ok(int w);
    return (w == 8) || (w == 16) || (w == 32) || (w == 64);
  endfunction

endpackage

// File: rtl/gpio_mmio_sync.sv
module gpio_mmio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_mmio_remap.sv
module gpio_mmio_remap #(
  parameter int WIDTH   = 32,
  parameter bit REVERSE = 1'b0
) (
  input  logic [WIDTH-1:0] a,
  output logic [WIDTH-1:0] b
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (REVERSE) begin : g_rev
      assign b[i] = a[WIDTH-1-i];
    end else begin : g_str
      assign b[i] = a[i];
    end
  end

endmodule

// File: rtl/gpio_mmio_outlatch.sv
module gpio_mmio_outlatch
  import gpio_mmio_pkg::*;
#(
  parameter int         WIDTH = 32,
  parameter out_style_e STYLE = OUT_SETCLR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_dat,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] set_rd
);

  logic [WIDTH-1:0] latch_nxt;

  always_comb begin
    latch_nxt = latch_q;
    case (STYLE)
      OUT_SINGLE: begin
        if (wr_dat) latch_nxt = wdata;
      end
      OUT_SETCLR: begin
        if (wr_set)      latch_nxt = latch_q | wdata;
        else if (wr_clr) latch_nxt = latch_q & ~wdata;
      end
      default: begin
        if (wr_set) latch_nxt = wdata;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= latch_nxt;
  end

  assign set_rd = (STYLE == OUT_SINGLE) ? '0 : latch_q;

  if (STYLE == OUT_SINGLE) begin : g_chk_single
    p_single_load_r2: assert property (@(posedge clk) disable iff (rst)
      wr_dat |=> latch_q == $past(wdata));
    p_single_keep_r2: assert property (@(posedge clk) disable iff (rst)
      !wr_dat |=> $stable(latch_q));
  end else if (STYLE == OUT_SETCLR) begin : g_chk_setclr
    p_setclr_set_r3: assert property (@(posedge clk) disable iff (rst)
      wr_set |=> (latch_q & $past(wdata)) == $past(wdata));
    p_setclr_clr_r3: assert property (@(posedge clk) disable iff (rst)
      wr_clr |=> (latch_q & $past(wdata)) == '0);
    p_setclr_keep_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_set || wr_clr) |=> ((latch_q ^ $past(latch_q)) & ~$past(wdata)) == '0);
    p_setclr_idle_r3: assert property (@(posedge clk) disable iff (rst)
      !(wr_set || wr_clr) |=> $stable(latch_q));
  end else begin : g_chk_setonly
    p_setonly_load_r4: assert property (@(posedge clk) disable iff (rst)
      wr_set |=> latch_q == $past(wdata));
    p_setonly_keep_r4: assert property (@(posedge clk) disable iff (rst)
      !wr_set |=> $stable(latch_q));
  end

endmodule

// File: rtl/gpio_mmio_dirctl.sv
module gpio_mmio_dirctl #(
  parameter int WIDTH      = 32,
  parameter bit DIR_OUT_EN = 1'b1,
  parameter bit DIR_IN_SEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_dir,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] oe_q,
  output logic [WIDTH-1:0] dir_rd
);

  localparam bit NO_DIR = !DIR_OUT_EN && !DIR_IN_SEL;
  localparam logic [WIDTH-1:0] OE_RESET = NO_DIR ? '1 : '0;

  logic [WIDTH-1:0] oe_nxt;

  always_comb begin
    oe_nxt = oe_q;
    if (wr_dir && !NO_DIR) begin
      oe_nxt = DIR_IN_SEL ? ~wdata : wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= OE_RESET;
    else     oe_q <= oe_nxt;
  end

  always_comb begin
    if (NO_DIR)          dir_rd = '0;
    else if (DIR_IN_SEL) dir_rd = ~oe_q;
    else                 dir_rd = oe_q;
  end

  if (NO_DIR) begin : g_chk_none
    p_dir_fixed_r7: assert property (@(posedge clk) disable iff (rst)
      wr_dir |=> &oe_q);
  end else if (DIR_IN_SEL) begin : g_chk_insel
    p_insel_load_r6: assert property (@(posedge clk) disable iff (rst)
      wr_dir |=> oe_q == ~$past(wdata));
    p_insel_keep_r6: assert property (@(posedge clk) disable iff (rst)
      !wr_dir |=> $stable(oe_q));
  end else begin : g_chk_outen
    p_outen_load_r5: assert property (@(posedge clk) disable iff (rst)
      wr_dir |=> oe_q == $past(wdata));
    p_outen_keep_r5: assert property (@(posedge clk) disable iff (rst)
      !wr_dir |=> $stable(oe_q));
  end

endmodule

// File: rtl/gpio_mmio.sv
module gpio_mmio
  import gpio_mmio_pkg::*;
#(
  parameter int         WIDTH       = 32,
  parameter out_style_e OUT_STYLE   = OUT_SETCLR,
  parameter bit         DIR_OUT_EN  = 1'b1,
  parameter bit         DIR_IN_SEL  = 1'b0,
  parameter bit         REVERSE     = 1'b0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  if (!width_ok(WIDTH)) begin : g_bad_width
    $error("gpio_mmio: WIDTH must be 8, 16, 32 or 64");
  end
  if (DIR_OUT_EN && DIR_IN_SEL) begin : g_bad_dir
    $error("gpio_mmio: output-enable and input-select direction are exclusive");
  end

  logic wr_dat, wr_set, wr_clr, wr_dir;

  assign wr_dat = wr_en && (addr == OFS_DATA);
  assign wr_set = wr_en && (addr == OFS_SET);
  assign wr_clr = wr_en && (addr == OFS_CLEAR);
  assign wr_dir = wr_en && (addr == OFS_DIR);

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] in_reg;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] set_rd;
  logic [WIDTH-1:0] oe_q;
  logic [WIDTH-1:0] dir_rd;
  logic [WIDTH-1:0] rd_mux;

  gpio_mmio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpio_mmio_remap #(.WIDTH(WIDTH), .REVERSE(REVERSE)) u_map_in (
    .a (pin_sync),
    .b (in_reg)
  );

  gpio_mmio_outlatch #(.WIDTH(WIDTH), .STYLE(OUT_STYLE)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_dat  (wr_dat),
    .wr_set  (wr_set),
    .wr_clr  (wr_clr),
    .wdata   (wdata),
    .latch_q (latch_q),
    .set_rd  (set_rd)
  );

  gpio_mmio_dirctl #(
    .WIDTH      (WIDTH),
    .DIR_OUT_EN (DIR_OUT_EN),
    .DIR_IN_SEL (DIR_IN_SEL)
  ) u_dir (
    .clk    (clk),
    .rst    (rst),
    .wr_dir (wr_dir),
    .wdata  (wdata),
    .oe_q   (oe_q),
    .dir_rd (dir_rd)
  );

  gpio_mmio_remap #(.WIDTH(WIDTH), .REVERSE(REVERSE)) u_map_out (
    .a (latch_q),
    .b (pin_out)
  );

  gpio_mmio_remap #(.WIDTH(WIDTH), .REVERSE(REVERSE)) u_map_oe (
    .a (oe_q),
    .b (pin_oe)
  );

  always_comb begin
    case (addr)
      OFS_DATA:  rd_mux = (oe_q & latch_q) | (~oe_q & in_reg);
      OFS_SET:   rd_mux = set_rd;
      OFS_CLEAR: rd_mux = '0;
      default:   rd_mux = dir_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  p_clear_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_CLEAR) |=> rdata == '0);
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  p_output_pins_drive_latch_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_DATA) |=> ((rdata ^ $past(latch_q)) & $past(oe_q)) == '0);

endmodule

// File: tb/gpio_mmio_tb_top.sv
module gpio_mmio_tb_top;

  localparam time TCLK = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] pin_in = '0;

  logic [31:0] rd_a, po_a, oe_a;
  logic [15:0] rd_b, po_b, oe_b;
  logic [7:0]  rd_c, po_c, oe_c;

  int n_chk = 0;
  int n_bad = 0;

  always #(TCLK/2) clk = ~clk;

  // set/clear style, 1 = output direction, straight numbering
  gpio_mmio #(
    .WIDTH(32), .OUT_STYLE(gpio_mmio_pkg::OUT_SETCLR),
    .DIR_OUT_EN(1'b1), .DIR_IN_SEL(1'b0), .REVERSE(1'b0)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata[31:0]), .rdata(rd_a), .pin_in(pin_in[31:0]),
    .pin_out(po_a), .pin_oe(oe_a)
  );

  // single-register style, 1 = input direction, reversed numbering
  gpio_mmio #(
    .WIDTH(16), .OUT_STYLE(gpio_mmio_pkg::OUT_SINGLE),
    .DIR_OUT_EN(1'b0), .DIR_IN_SEL(1'b1), .REVERSE(1'b1)
  ) dut_b (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata[15:0]), .rdata(rd_b), .pin_in(pin_in[15:0]),
    .pin_out(po_b), .pin_oe(oe_b)
  );

  // set-only style, no direction register
  gpio_mmio #(
    .WIDTH(8), .OUT_STYLE(gpio_mmio_pkg::OUT_SETONLY),
    .DIR_OUT_EN(1'b0), .DIR_IN_SEL(1'b0), .REVERSE(1'b0)
  ) dut_c (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata[7:0]), .rdata(rd_c), .pin_in(pin_in[7:0]),
    .pin_out(po_c), .pin_oe(oe_c)
  );

  // per-instance configuration: style 0 single / 1 setclr / 2 setonly,
  // dir 0 none / 1 output-enable / 2 input-select
  int unsigned cw    [3] = '{32, 16, 8};
  int unsigned cstyle[3] = '{1, 0, 2};
  int unsigned cdir  [3] = '{1, 2, 0};
  bit          crev  [3] = '{1'b0, 1'b1, 1'b0};

  logic [63:0] m_latch [3];
  logic [63:0] m_dir   [3];

  function automatic logic [63:0] wmask(int k);
    return (64'd1 << cw[k]) - 64'd1;
  endfunction

  function automatic logic [63:0] flip(logic [63:0] x, int k);
    logic [63:0] r = '0;
    for (int i = 0; i < 64; i++) if (i < cw[k]) r[i] = x[cw[k]-1-i];
    return r;
  endfunction

  function automatic logic [63:0] to_pins(logic [63:0] x, int k);
    return crev[k] ? flip(x, k) : (x & wmask(k));
  endfunction

  function automatic logic [63:0] exp_oe_reg(int k);
    case (cdir[k])
      0:       return wmask(k);
      1:       return m_dir[k] & wmask(k);
      default: return ~m_dir[k] & wmask(k);
    endcase
  endfunction

  function automatic logic [63:0] exp_read(int k, logic [1:0] a);
    logic [63:0] inr, oe;
    case (a)
      2'd0: begin
        inr = to_pins(pin_in, k);
        oe  = exp_oe_reg(k);
        return ((oe & m_latch[k]) | (~oe & inr)) & wmask(k);
      end
      2'd1:    return (cstyle[k] == 0) ? 64'd0 : m_latch[k];
      2'd2:    return 64'd0;
      default: return (cdir[k] == 0) ? 64'd0 : m_dir[k];
    endcase
  endfunction

  function automatic logic [63:0] act_rd(int k);
    case (k)
      0:       return {32'd0, rd_a};
      1:       return {48'd0, rd_b};
      default: return {56'd0, rd_c};
    endcase
  endfunction

  function automatic logic [63:0] act_po(int k);
    case (k)
      0:       return {32'd0, po_a};
      1:       return {48'd0, po_b};
      default: return {56'd0, po_c};
    endcase
  endfunction

  function automatic logic [63:0] act_oe(int k);
    case (k)
      0:       return {32'd0, oe_a};
      1:       return {48'd0, oe_b};
      default: return {56'd0, oe_c};
    endcase
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string out_tag(int k);
    case (cstyle[k])
      0:       return "R2";
      1:       return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic string oe_tag(int k);
    case (cdir[k])
      0:       return "R7";
      1:       return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_pins();
    for (int k = 0; k < 3; k++) begin
      chk(out_tag(k), "pin_out", act_po(k), to_pins(m_latch[k], k));
      chk(oe_tag(k), "pin_oe", act_oe(k), to_pins(exp_oe_reg(k), k));
    end
  endtask

  task automatic model_write(logic [1:0] a, logic [63:0] d);
    for (int k = 0; k < 3; k++) begin
      logic [63:0] dm = d & wmask(k);
      case (a)
        2'd0: if (cstyle[k] == 0) m_latch[k] = dm;
        2'd1: begin
          if (cstyle[k] == 1)      m_latch[k] = m_latch[k] | dm;
          else if (cstyle[k] == 2) m_latch[k] = dm;
        end
        2'd2: if (cstyle[k] == 1) m_latch[k] = m_latch[k] & ~dm;
        default: if (cdir[k] != 0) m_dir[k] = dm;
      endcase
    end
  endtask

  task automatic do_write(logic [1:0] a, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    check_pins();
  endtask

  task automatic do_read(logic [1:0] a);
    string tag;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (a == 2'd0)      tag = "R9";
      else if (a == 2'd3) tag = oe_tag(k);
      else                tag = "R10";
      chk(tag, "rdata", act_rd(k), exp_read(k, a));
    end
  endtask

  task automatic set_pins(logic [63:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] held [3];
    void'($urandom(32'h5eed_0042));
    for (int k = 0; k < 3; k++) begin
      m_latch[k] = '0;
      m_dir[k]   = (cdir[k] == 2) ? wmask(k) : 64'd0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11: reset state on the pins and in the direction registers
    chk("R11", "pin_out a", act_po(0), 64'd0);
    chk("R11", "pin_oe a", act_oe(0), 64'd0);
    chk("R11", "pin_oe b", act_oe(1), 64'd0);
    chk("R11", "pin_oe c", act_oe(2), 64'hFF);
    do_read(2'd3);
    chk("R11", "dir b all ones", act_rd(1), 64'hFFFF);

    // R3 / R4: set then clear; R2: single ignores set and clear
    do_write(2'd1, 64'h0000_00F0);
    do_write(2'd2, 64'h0000_0030);
    chk("R3", "setclr latch after clear", act_po(0), 64'h0000_00C0);
    chk("R4", "setonly ignores clear", act_po(2), 64'hF0);
    do_read(2'd1);
    do_read(2'd2);

    // R1: full-width set on the 8-bit instance
    do_write(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1", "8-bit full width", act_po(2), 64'hFF);

    // R8: single write of bit 0 on reversed instance lands on pin 15
    do_write(2'd0, 64'h0000_0001);
    chk("R8", "reversed pin", act_po(1), 64'h8000);

    // R5 / R6 / R7: direction writes
    do_write(2'd3, 64'h0000_000F);
    chk("R5", "outen oe", act_oe(0), 64'h0000_000F);
    chk("R6", "insel oe", act_oe(1), flip(64'hFFF0, 1));
    chk("R7", "none oe", act_oe(2), 64'hFF);
    do_read(2'd3);

    // R9: mixed readback with two input patterns
    set_pins(64'hA5A5_5A5A_3C3C_C3C3);
    do_read(2'd0);
    set_pins(64'h0123_4567_89AB_CDEF);
    do_read(2'd0);

    // R12: rdata held through an idle cycle
    for (int k = 0; k < 3; k++) held[k] = act_rd(k);
    @(negedge clk);
    for (int k = 0; k < 3; k++) chk("R12", "rdata held", act_rd(k), held[k]);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned op = $urandom_range(0, 3);
      logic [1:0] a = 2'($urandom_range(0, 3));
      logic [63:0] d = {$urandom, $urandom};
      if (op == 0) set_pins({$urandom, $urandom});
      if (op <= 1) do_read(a);
      else         do_write(a, d);
    end

    // reset in mid-run returns to the reset state (R11)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      m_latch[k] = '0;
      m_dir[k]   = (cdir[k] == 2) ? wmask(k) : 64'd0;
    end
    chk("R11", "pin_out b after reset", act_po(1), 64'd0);
    check_pins();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule